// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Status

This block holds the two byte queues that sit between a register bus and a UART serializer. The host writes bytes into the transmit queue and reads bytes out of the receive queue. The serializer drains the transmit queue and fills the receive queue. Both queues keep an occupancy count. Misuse by the host sets one of two sticky error flags, and both flags clear when the host reads the status word.

A control write can flush either queue and sets two trigger-level codes. The block drives one request output per queue from its count and the selected threshold. The two code tables run in opposite directions. A status word and two line-status bits carry occupancy, idle state and the error flags to the rest of the UART, which does the framing, baud generation, interrupt encoding and DMA.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both counts are 0, both error flags are 0, both trigger codes are 0, `ctl_rdata` is 0x00, `lsr_rx_empty` is 1 and `lsr_tx_full` is 0.
- R2: A `host_wr` pushes `host_wdata` into the transmit queue. `ser_tx_pop` removes the oldest byte, and `ser_tx_data` shows that byte, or 0x00 when the queue is empty. A pop from an empty queue changes nothing.
- R3: `ser_rx_push` stores `ser_rx_data` in the receive queue. `host_rd` removes the oldest byte, and `host_rdata` shows that byte. When the queue is empty `host_rdata` is 0x00, and a read leaves the count unchanged.
- R4: `stat_word[21:16]` holds the receive count and `stat_word[29:24]` holds the transmit count. Each count stops at 32. A push into a full queue is dropped and the count stays the same.
- R5: `stat_word[2]` sets on the cycle after a `host_rd` that finds the receive queue empty. It stays set until a cycle with `stat_rd`, after which it reads 0. If a new underrun happens in the same cycle as `stat_rd`, the flag stays set.
- R6: `stat_word[3]` behaves the same way for a `host_wr` that finds the transmit queue full.
- R7: `stat_word[0]` is 1 exactly when the transmit queue is empty and `ser_tx_busy` is 0. `stat_word[1]` is 1 exactly when the receive queue is empty and `ser_rx_busy` is 0.
- R8: A `ctl_wr` with `ctl_wdata[1]` set empties the receive queue. A `ctl_wr` with `ctl_wdata[2]` set empties the transmit queue. A flush wins over any push or pop in the same cycle, and `ctl_rdata[1]` and `ctl_rdata[2]` always read 0.
- R9: `ctl_wdata[5:4]` holds the transmit trigger code. `tx_trig_req` is 1 while the transmit count is greater than 16, 8, 4 or 1 for codes 0, 1, 2 and 3, and the code reads back on `ctl_rdata[5:4]`.
- R10: `ctl_wdata[7:6]` holds the receive trigger code. `rx_trig_req` is 1 while the receive count is greater than 1, 4, 8 or 16 for codes 0, 1, 2 and 3, and the code reads back on `ctl_rdata[7:6]`.
- R11: `lsr_tx_full` is 1 exactly when the transmit count is 32, and `lsr_rx_empty` is 1 exactly when the receive count is 0. All bits of `stat_word` not named above read 0.
- R12: If a push and a pop reach the same queue in the same cycle, the pop always takes place. The push takes place only if the queue was not full at the start of that cycle, so a full queue ends that cycle holding 31 entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host push into the transmit queue |
| host_wdata | input | 8 | Byte to push |
| host_rd | input | 1 | Host pop from the receive queue |
| host_rdata | output | 8 | Oldest receive byte, or 0x00 when empty |
| stat_rd | input | 1 | Status word read strobe; clears the sticky flags |
| stat_word | output | 32 | Idle bits, sticky flags and both counts |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Flush bits and trigger codes |
| ctl_rdata | output | 8 | Trigger codes read back; flush bits read 0 |
| ser_tx_pop | input | 1 | Serializer takes a transmit byte |
| ser_tx_data | output | 8 | Oldest transmit byte, or 0x00 when empty |
| ser_tx_busy | input | 1 | Transmit shift register is busy |
| ser_rx_push | input | 1 | Serializer delivers a received byte |
| ser_rx_data | input | 8 | Received byte |
| ser_rx_busy | input | 1 | Receiver is busy with a character |
| lsr_tx_full | output | 1 | Transmit queue is full |
| lsr_rx_empty | output | 1 | Receive queue is empty |
| tx_trig_req | output | 1 | Transmit count is above the selected threshold |
| rx_trig_req | output | 1 | Receive count is above the selected threshold |

## Verification
Two pairs of events can fall in the same cycle. The first is a status read against a new underrun or overrun. The bench raises `stat_rd` in the same cycle as a read from an empty receive queue or a write to a full transmit queue, and expects the flag to remain set afterwards. The second is a flush against a push. Here the bench issues a push together with the flush and expects a count of zero. It also pushes into a full transmit queue while the serializer pops, and expects the count to be 31 and the overrun flag to be set.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    // Width of each count field in the status word
    localparam int unsigned CNT_FIELD_W = 6;

    // Status word bit positions (neighbouring logic decodes these)
    localparam int unsigned ST_TX_IDLE  = 0;
    localparam int unsigned ST_RX_IDLE  = 1;
    localparam int unsigned ST_RX_UNDER = 2;
    localparam int unsigned ST_TX_OVER  = 3;
    localparam int unsigned ST_RX_CNT   = 16;
    localparam int unsigned ST_TX_CNT   = 24;

    // Control byte bit positions
    localparam int unsigned CT_RX_FLUSH = 1;
    localparam int unsigned CT_TX_FLUSH = 2;

    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
    } trig_cfg_t;

    // Transmit table: code 0 has the highest threshold
    function automatic int unsigned tx_threshold(input logic [1:0] code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 8;
            2'd2:    return 4;
            default: return 1;
        endcase
    endfunction

    // Receive table: code 0 has the lowest threshold
    function automatic int unsigned rx_threshold(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/byte_fifo.sv
// Synchronous queue with flush. DEPTH must be a power of two.
module byte_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign head  = empty ? '0 : mem_q[st_q.rptr];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wptr = st_q.wptr + AW'(1);
            if (do_pop)  st_d.rptr = st_q.rptr + AW'(1);
            if (do_push && !do_pop)      st_d.cnt = st_q.cnt + CW'(1);
            else if (!do_push && do_pop) st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wptr] <= push_data;
    end

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> count == $past(count));
    p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> count == $past(count));
    p_flush_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    p_full_popped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full && !flush) |=> count == CW'(DEPTH - 1));

endmodule

// File: rtl/sticky_flag.sv
// Flag set by an event, cleared by a read; an event in the read cycle wins.
module sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd_clr,
    output logic flag
);

    typedef struct packed {
        logic set;
    } flag_state_t;

    flag_state_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (evt)         fl_d.set = 1'b1;
        else if (rd_clr) fl_d.set = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flag = fl_q.set;

    p_evt_sets_r5_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);
    p_rd_clears_r5_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !evt) |=> !flag);

endmodule

// File: rtl/trig_cmp.sv
// Compares a queue count with the threshold picked by a 2-bit code.
module trig_cmp #(
    parameter int unsigned CW = 6,
    parameter bit RX_TABLE = 1'b0
) (
    input  logic [1:0]    code,
    input  logic [CW-1:0] count,
    output logic          req
);

    int unsigned thr;

    generate
        if (RX_TABLE) begin : g_rx
            always_comb thr = uart_fifo_pkg::rx_threshold(code);
        end else begin : g_tx
            always_comb thr = uart_fifo_pkg::tx_threshold(code);
        end
    endgenerate

    assign req = (32'(count) > thr);

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    input  logic        host_rd,
    output logic [7:0]  host_rdata,
    input  logic        stat_rd,
    output logic [31:0] stat_word,
    input  logic        ctl_wr,
    input  logic [7:0]  ctl_wdata,
    output logic [7:0]  ctl_rdata,
    input  logic        ser_tx_pop,
    output logic [7:0]  ser_tx_data,
    input  logic        ser_tx_busy,
    input  logic        ser_rx_push,
    input  logic [7:0]  ser_rx_data,
    input  logic        ser_rx_busy,
    output logic        lsr_tx_full,
    output logic        lsr_rx_empty,
    output logic        tx_trig_req,
    output logic        rx_trig_req
);
    import uart_fifo_pkg::*;

    trig_cfg_t cfg_d, cfg_q;
    logic flush_rx, flush_tx;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic under_evt, over_evt, under_flag, over_flag;
    logic [CNT_FIELD_W-1:0] tx_cnt_f, rx_cnt_f;
    logic unused_ctl;

    assign unused_ctl = ^{ctl_wdata[0], ctl_wdata[3], rx_full};

    // Control register
    always_comb begin
        cfg_d = cfg_q;
        if (ctl_wr) begin
            cfg_d.tx_code = ctl_wdata[5:4];
            cfg_d.rx_code = ctl_wdata[7:6];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign flush_rx  = ctl_wr && ctl_wdata[CT_RX_FLUSH];
    assign flush_tx  = ctl_wr && ctl_wdata[CT_TX_FLUSH];
    assign ctl_rdata = {cfg_q.rx_code, cfg_q.tx_code, 4'b0000};

    byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_tx),
        .push      (host_wr),
        .push_data (host_wdata),
        .pop       (ser_tx_pop),
        .head      (ser_tx_data),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_rx),
        .push      (ser_rx_push),
        .push_data (ser_rx_data),
        .pop       (host_rd),
        .head      (host_rdata),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    assign under_evt = host_rd && rx_empty;
    assign over_evt  = host_wr && tx_full;

    sticky_flag u_under (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (under_evt),
        .rd_clr (stat_rd),
        .flag   (under_flag)
    );

    sticky_flag u_over (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (over_evt),
        .rd_clr (stat_rd),
        .flag   (over_flag)
    );

    trig_cmp #(.CW(CW), .RX_TABLE(1'b0)) u_tx_trig (
        .code  (cfg_q.tx_code),
        .count (tx_cnt),
        .req   (tx_trig_req)
    );

    trig_cmp #(.CW(CW), .RX_TABLE(1'b1)) u_rx_trig (
        .code  (cfg_q.rx_code),
        .count (rx_cnt),
        .req   (rx_trig_req)
    );

    assign tx_cnt_f = CNT_FIELD_W'(tx_cnt);
    assign rx_cnt_f = CNT_FIELD_W'(rx_cnt);

    always_comb begin
        stat_word = '0;
        stat_word[ST_TX_IDLE]  = tx_empty && !ser_tx_busy;
        stat_word[ST_RX_IDLE]  = rx_empty && !ser_rx_busy;
        stat_word[ST_RX_UNDER] = under_flag;
        stat_word[ST_TX_OVER]  = over_flag;
        stat_word[ST_RX_CNT +: CNT_FIELD_W] = rx_cnt_f;
        stat_word[ST_TX_CNT +: CNT_FIELD_W] = tx_cnt_f;
    end

    assign lsr_tx_full  = tx_full;
    assign lsr_rx_empty = rx_empty;

    p_empty_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rx_empty |-> host_rdata == 8'h00);
    p_tx_trig_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(1)) |-> !tx_trig_req);
    p_rx_trig_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt <= CW'(1)) |-> !rx_trig_req);
    p_flush_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[2:1] == 2'b00);
    p_idle_needs_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[ST_TX_IDLE] |-> !ser_tx_busy && lsr_tx_full == 1'b0);

endmodule

// File: tb/uart_fifo_pair_bench.sv
module uart_fifo_pair_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 0, host_rd = 0, stat_rd = 0, ctl_wr = 0;
    logic ser_tx_pop = 0, ser_tx_busy = 0, ser_rx_push = 0, ser_rx_busy = 0;
    logic [7:0] host_wdata = 0, ctl_wdata = 0, ser_rx_data = 0;
    logic [7:0] host_rdata, ctl_rdata, ser_tx_data;
    logic [31:0] stat_word;
    logic lsr_tx_full, lsr_rx_empty, tx_trig_req, rx_trig_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_fifo_pair u_uart_fifo_pair (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .stat_rd(stat_rd), .stat_word(stat_word),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data), .ser_tx_busy(ser_tx_busy),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .ser_rx_busy(ser_rx_busy),
        .lsr_tx_full(lsr_tx_full), .lsr_rx_empty(lsr_rx_empty),
        .tx_trig_req(tx_trig_req), .rx_trig_req(rx_trig_req)
    );

    typedef struct packed {
        logic       hw;  logic [7:0] hd;
        logic       hr;  logic       sp;
        logic       su;  logic [7:0] sd;
        logic       cw;  logic [7:0] cd;
        logic       sr;
        logic [5:0] etx; logic [5:0] erx; logic [3:0] efl;
    } vec_t;

    // Applied after reset, one cycle each; counts and status[3:0] checked after the edge
    localparam vec_t VECS [0:11] = '{
        '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 6'd1, 6'd0, 4'b0010}, // R2 push
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h5C, 1'b0, 8'h00, 1'b0, 6'd1, 6'd1, 4'b0000}, // R3 rx push
        '{1'b1, 8'hB2, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 6'd2, 6'd0, 4'b0010}, // R3 pop
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 6'd2, 6'd0, 4'b0110}, // R5 underrun
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 6'd2, 6'd0, 4'b0010}, // R5 cleared
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 6'd1, 6'd0, 4'b0010}, // R2 ser pop
        '{1'b1, 8'hC3, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 6'd1, 6'd0, 4'b0010}, // R12 both
        '{1'b1, 8'hD4, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h04, 1'b0, 6'd0, 6'd0, 4'b0011}, // R8 tx flush
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h33, 1'b1, 8'h02, 1'b0, 6'd0, 6'd0, 4'b0011}, // R8 rx flush
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 6'd0, 6'd0, 4'b0111}, // R5 event wins
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 6'd0, 6'd0, 4'b0011}, // R5 cleared
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 6'd0, 6'd1, 4'b0001}  // R2 empty pop
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        host_wr = 0; host_rd = 0; stat_rd = 0; ctl_wr = 0;
        ser_tx_pop = 0; ser_rx_push = 0;
    endtask

    task automatic ctl(input logic [7:0] v);
        ctl_wr = 1; ctl_wdata = v; tick();
    endtask

    function automatic int exp_tx_thr(input int code);
        case (code) 0: return 16; 1: return 8; 2: return 4; default: return 1; endcase
    endfunction

    function automatic int exp_rx_thr(input int code);
        case (code) 0: return 1; 1: return 4; 2: return 8; default: return 16; endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "status", stat_word, 32'h0000_0003);
        chk("R1", "ctl_rdata", {24'h0, ctl_rdata}, 32'h0);
        chk("R1", "lsr", {30'h0, lsr_tx_full, lsr_rx_empty}, 32'h1);
        chk("R1", "triggers", {30'h0, tx_trig_req, rx_trig_req}, 32'h0);

        // Vector table
        for (int i = 0; i < 12; i++) begin
            host_wr = VECS[i].hw; host_wdata = VECS[i].hd; host_rd = VECS[i].hr;
            ser_tx_pop = VECS[i].sp; ser_rx_push = VECS[i].su; ser_rx_data = VECS[i].sd;
            ctl_wr = VECS[i].cw; ctl_wdata = VECS[i].cd; stat_rd = VECS[i].sr;
            tick();
            chk("R4", $sformatf("vec%0d tx count", i), {26'h0, stat_word[29:24]}, {26'h0, VECS[i].etx});
            chk("R4", $sformatf("vec%0d rx count", i), {26'h0, stat_word[21:16]}, {26'h0, VECS[i].erx});
            chk("R5/R6/R7", $sformatf("vec%0d flags", i), {28'h0, stat_word[3:0]}, {28'h0, VECS[i].efl});
        end
        chk("R3", "rx head after table", {24'h0, host_rdata}, 32'h11);
        chk("R8", "flush bits read 0", {24'h0, ctl_rdata}, 32'h0);
        chk("R2", "empty tx head", {24'h0, ser_tx_data}, 32'h0);

        // R7 busy inputs hold off idle
        ser_tx_busy = 1; ser_rx_busy = 1; ctl(8'h02);
        chk("R7", "idle bits busy", {30'h0, stat_word[1:0]}, 32'h0);
        ser_tx_busy = 0; ser_rx_busy = 0;
        @(negedge clk);
        chk("R7", "idle bits free", {30'h0, stat_word[1:0]}, 32'h3);

        // R4 R6 R11 fill transmit queue
        for (int i = 0; i < 32; i++) begin
            host_wr = 1; host_wdata = 8'(i + 8'h40); tick();
        end
        chk("R4", "tx count full", {26'h0, stat_word[29:24]}, 32'd32);
        chk("R11", "tx full", {31'h0, lsr_tx_full}, 32'h1);
        host_wr = 1; host_wdata = 8'hEE; tick();
        chk("R4", "tx count after drop", {26'h0, stat_word[29:24]}, 32'd32);
        chk("R6", "overrun set", {31'h0, stat_word[3]}, 32'h1);
        stat_rd = 1; host_wr = 1; tick();
        chk("R6", "overrun event wins", {31'h0, stat_word[3]}, 32'h1);
        stat_rd = 1; tick();
        chk("R6", "overrun cleared", {31'h0, stat_word[3]}, 32'h0);
        chk("R2", "head oldest", {24'h0, ser_tx_data}, 32'h40);
        host_wr = 1; host_wdata = 8'hEF; ser_tx_pop = 1; tick();
        chk("R12", "full push+pop count", {26'h0, stat_word[29:24]}, 32'd31);
        chk("R12", "full push dropped flag", {31'h0, stat_word[3]}, 32'h1);
        chk("R11", "tx not full", {31'h0, lsr_tx_full}, 32'h0);
        for (int i = 1; i < 4; i++) begin
            chk("R2", $sformatf("tx order %0d", i), {24'h0, ser_tx_data}, 32'(i + 8'h40));
            ser_tx_pop = 1; tick();
        end
        chk("R11", "unused status bits", stat_word & 32'hC0C0_FFF0, 32'h0);

        // R3 R4 fill receive queue past the limit
        ctl(8'h06);
        for (int i = 0; i < 33; i++) begin
            ser_rx_push = 1; ser_rx_data = 8'(i + 8'h80); tick();
        end
        chk("R4", "rx count saturates", {26'h0, stat_word[21:16]}, 32'd32);
        chk("R11", "rx not empty", {31'h0, lsr_rx_empty}, 32'h0);
        for (int i = 0; i < 3; i++) begin
            chk("R3", $sformatf("rx order %0d", i), {24'h0, host_rdata}, 32'(i + 8'h80));
            host_rd = 1; tick();
        end
        chk("R12", "rx push+pop", 32'(stat_word[21:16]), 32'd29);
        ser_rx_push = 1; ser_rx_data = 8'h55; host_rd = 1; tick();
        chk("R12", "rx simultaneous", {26'h0, stat_word[21:16]}, 32'd29);

        // R9 transmit trigger sweep
        ctl(8'h04);
        for (int n = 0; n < 19; n++) begin
            for (int c = 0; c < 4; c++) begin
                ctl(8'(c << 4));
                chk("R9", $sformatf("code %0d count %0d", c, n), {31'h0, tx_trig_req},
                    {31'h0, (n > exp_tx_thr(c))});
            end
            chk("R9", "code readback", {24'h0, ctl_rdata}, 32'h30);
            host_wr = 1; host_wdata = 8'(n); tick();
        end

        // R10 receive trigger sweep
        ctl(8'h02);
        for (int n = 0; n < 19; n++) begin
            for (int c = 0; c < 4; c++) begin
                ctl(8'(c << 6));
                chk("R10", $sformatf("code %0d count %0d", c, n), {31'h0, rx_trig_req},
                    {31'h0, (n > exp_rx_thr(c))});
            end
            chk("R10", "code readback", {24'h0, ctl_rdata}, 32'hC0);
            ser_rx_push = 1; ser_rx_data = 8'(n); tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule